// File: doc/BRIEF.md
# Sixteen-bit ALU with status flags

This block is the integer arithmetic and logic stage of a 16-bit microcontroller datapath. Each cycle it may take two operand values, a four-bit operation code, a byte/word select and a valid strobe. It adds, subtracts, shifts by one place or applies a bitwise function. It then registers the result together with five status flags: carry, zero, negative, overflow and digit carry. Operands arrive already fetched, and the registered result is handed to whatever stage performs writeback.

Arithmetic is two's complement. For subtraction the carry flag means "no borrow" and the digit-carry flag means "no borrow out of the low nibble". The add-with-carry and subtract-with-borrow codes take the registered carry as their input. For those two codes the zero flag can only be cleared, so a zero test can span several chained words. In byte mode the operation works on the low eight bits and the flags are taken at bit 7. The upper result byte is copied from operand A.

Each flag is written only by the operations that are defined to affect it. All other flags hold their previous values. Idle cycles and reserved codes leave all registered state unchanged.

Top module: `alu16_status`

## Requirements
- R1: While rst_n is low, and after it is released until the first valid operation, result is 0 and all five flags are 0.
- R2: Op code 0 (add) gives A+B. Op code 1 (add with carry) gives A+B+C, where C is the registered carry flag. The carry flag is set to the carry out of the active most significant bit.
- R3: Op code 2 (subtract) gives A-B. Op code 3 (subtract with borrow) gives A-B-(1-C). The carry flag is 1 when no borrow occurs. The digit-carry flag is 1 when the low nibble does not borrow.
- R4: For op codes 0 to 3, the overflow flag is set when the signed result does not fit in the active width.
- R5: For op codes 0 and 1, the digit-carry flag is the carry out of bit 3. This holds in both byte and word mode.
- R6: Every defined op sets the negative flag to the active most significant result bit. For op codes 0, 2 and 4 to 9, the zero flag is 1 exactly when the active result bits are all 0. For op codes 1 and 3, the zero flag becomes its old value ANDed with that test, so these codes can only clear it.
- R7: Op codes 4 (AND), 5 (OR) and 6 (XOR) apply the bitwise function. They update zero and negative, and leave carry, overflow and digit carry unchanged.
- R8: Op code 7 shifts left by one place and fills with 0. Op code 8 shifts right by one place and fills with 0. Op code 9 shifts right by one place and keeps the sign bit. Each shift loads the carry flag with the bit shifted out, and leaves overflow and digit carry unchanged.
- R9: With byte_mode high, the operation uses bits 7:0 only, and all flags refer to bit 7. Result bits 15:8 equal operand A bits 15:8.
- R10: When op_valid is low, or the op code is 10 to 15, result and all flags keep their values in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Perform op_code this cycle |
| op_code | input | 4 | Operation select, codes 0 to 9 defined |
| byte_mode | input | 1 | 1 selects the 8-bit lane |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result | output | 16 | Registered result |
| flag_c | output | 1 | Carry, or no-borrow on subtraction |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_ov | output | 1 | Signed overflow |
| flag_dc | output | 1 | Nibble carry, or nibble no-borrow |

## Verification
The assertions assume that the inputs are settled at each rising edge and that op_code and byte_mode carry no unknown bits while op_valid is high. The bench keeps to this by driving every input on the falling edge, and it leaves op_valid low when it wants no operation. Because reserved codes must have no effect, the stimulus deliberately mixes in codes 10 to 15 and idle cycles. It also chains carry-in operations so that the hold and sticky rules for the flags are actually exercised, not just reached by chance.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBB = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SHL  = 4'd7,
        OP_LSR  = 4'd8,
        OP_ASR  = 4'd9
    } alu_op_e;

    localparam logic [OPC_W-1:0] OP_LAST = 4'd9;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic ov;
        logic dc;
    } alu_flags_t;
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              cin,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] sum,
    output logic              c_out,
    output logic              dc_out,
    output logic              ov_out
);
    localparam int HALF_W = DATA_W / 2;
    localparam int NIB_W  = 4;

    logic [DATA_W-1:0] bx;
    logic [DATA_W:0]   full_sum;
    logic [HALF_W:0]   lane_sum;
    logic [NIB_W:0]    nib_sum;
    int                msb;

    always_comb begin
        bx       = sub ? ~b : b;
        full_sum = {1'b0, a} + {1'b0, bx} + {{DATA_W{1'b0}}, cin};
        lane_sum = {1'b0, a[HALF_W-1:0]} + {1'b0, bx[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
        nib_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, bx[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
        msb      = byte_mode ? HALF_W - 1 : DATA_W - 1;
        sum      = full_sum[DATA_W-1:0];
        c_out    = byte_mode ? lane_sum[HALF_W] : full_sum[DATA_W];
        dc_out   = nib_sum[NIB_W];
        ov_out   = (a[msb] == bx[msb]) && (sum[msb] != a[msb]);
    end
endmodule

// File: rtl/alu16_logsh.sv
module alu16_logsh
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [OPC_W-1:0]  op,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] res,
    output logic              c_out
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] shl_w, lsr_w, asr_w;
    logic [HALF_W-1:0] shl_b, lsr_b, asr_b;

    always_comb begin
        shl_w = {a[DATA_W-2:0], 1'b0};
        lsr_w = {1'b0, a[DATA_W-1:1]};
        asr_w = {a[DATA_W-1], a[DATA_W-1:1]};
        shl_b = {a[HALF_W-2:0], 1'b0};
        lsr_b = {1'b0, a[HALF_W-1:1]};
        asr_b = {a[HALF_W-1], a[HALF_W-1:1]};
        res   = '0;
        c_out = a[0];
        case (alu_op_e'(op))
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_SHL: begin
                res   = byte_mode ? {{HALF_W{1'b0}}, shl_b} : shl_w;
                c_out = byte_mode ? a[HALF_W-1] : a[DATA_W-1];
            end
            OP_LSR: res = byte_mode ? {{HALF_W{1'b0}}, lsr_b} : lsr_w;
            OP_ASR: res = byte_mode ? {{HALF_W{1'b0}}, asr_b} : asr_w;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu16_status.sv
module alu16_status
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_ov,
    output logic              flag_dc
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        alu_flags_t        fl;
    } alu_state_t;

    alu_state_t st_d, st_q;

    logic              is_arith, is_sub, is_shift, use_cin, cin, defined;
    logic [DATA_W-1:0] as_sum, ls_res, lane_res;
    logic              as_c, as_dc, as_ov, ls_c;
    logic              zero_now, neg_now;

    always_comb begin
        defined  = op_code <= OP_LAST;
        is_arith = op_code <= OP_SUBB;
        is_sub   = (op_code == OP_SUB) || (op_code == OP_SUBB);
        is_shift = (op_code >= OP_SHL) && defined;
        use_cin  = (op_code == OP_ADDC) || (op_code == OP_SUBB);
        cin      = use_cin ? st_q.fl.c : is_sub;
    end

    alu16_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a         (opnd_a),
        .b         (opnd_b),
        .sub       (is_sub),
        .cin       (cin),
        .byte_mode (byte_mode),
        .sum       (as_sum),
        .c_out     (as_c),
        .dc_out    (as_dc),
        .ov_out    (as_ov)
    );

    alu16_logsh #(.DATA_W(DATA_W)) u_logsh (
        .a         (opnd_a),
        .b         (opnd_b),
        .op        (op_code),
        .byte_mode (byte_mode),
        .res       (ls_res),
        .c_out     (ls_c)
    );

    always_comb begin
        st_d     = st_q;
        lane_res = is_arith ? as_sum : ls_res;
        zero_now = byte_mode ? (lane_res[HALF_W-1:0] == '0) : (lane_res == '0);
        neg_now  = byte_mode ? lane_res[HALF_W-1] : lane_res[DATA_W-1];
        if (op_valid && defined) begin
            st_d.res  = byte_mode ? {opnd_a[DATA_W-1:HALF_W], lane_res[HALF_W-1:0]} : lane_res;
            st_d.fl.z = use_cin ? (st_q.fl.z & zero_now) : zero_now;
            st_d.fl.n = neg_now;
            if (is_arith) begin
                st_d.fl.c  = as_c;
                st_d.fl.ov = as_ov;
                st_d.fl.dc = as_dc;
            end else if (is_shift) begin
                st_d.fl.c = ls_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result  = st_q.res;
    assign flag_c  = st_q.fl.c;
    assign flag_z  = st_q.fl.z;
    assign flag_n  = st_q.fl.n;
    assign flag_ov = st_q.fl.ov;
    assign flag_dc = st_q.fl.dc;
endmodule

// File: rtl/alu16_status_chk.sv
module alu16_status_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic              byte_mode,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] result,
    input logic              flag_c,
    input logic              flag_z,
    input logic              flag_n,
    input logic              flag_ov,
    input logic              flag_dc
);
    localparam int HALF_W = DATA_W / 2;

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code > 4'd9) |=> ($stable(result) && $stable(flag_c) && $stable(flag_z)
            && $stable(flag_n) && $stable(flag_ov) && $stable(flag_dc)));

    p_logic_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd4 && op_code <= 4'd6) |=>
            ($stable(flag_c) && $stable(flag_ov) && $stable(flag_dc)));

    p_shift_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd7 && op_code <= 4'd9) |=> ($stable(flag_ov) && $stable(flag_dc)));

    p_zero_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd1 || op_code == 4'd3) && !flag_z) |=> !flag_z);

    p_zero_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 4'd9 && !byte_mode) |=> (flag_z == 1'b0 || result == '0));

    p_byte_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 4'd9 && byte_mode) |=>
            (result[DATA_W-1:HALF_W] == $past(opnd_a[DATA_W-1:HALF_W])
             && flag_n == result[HALF_W-1]));
endmodule

bind alu16_status alu16_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .byte_mode (byte_mode),
    .opnd_a    (opnd_a),
    .result    (result),
    .flag_c    (flag_c),
    .flag_z    (flag_z),
    .flag_n    (flag_n),
    .flag_ov   (flag_ov),
    .flag_dc   (flag_dc)
);

// File: tb/alu16_status_tb.sv
module alu16_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        byte_mode = 1'b0;
    logic [15:0] opnd_a = 16'd0, opnd_b = 16'd0;
    logic [15:0] result;
    logic        flag_c, flag_z, flag_n, flag_ov, flag_dc;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    int m_res = 0;
    bit m_c = 0, m_z = 0, m_n = 0, m_ov = 0, m_dc = 0;

    always #5 clk = ~clk;

    alu16_status u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .byte_mode(byte_mode), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_ov(flag_ov), .flag_dc(flag_dc)
    );

    task automatic model(input int op, input int a, input int b, input bit bm, input bit v);
        int w, mask, half, am, bv, r, s, sa, sb, t, cin, bor;
        bit c, dc, ov;
        if (!v || op > 9) return;
        w = bm ? 8 : 16;
        mask = (1 << w) - 1;
        half = 1 << (w - 1);
        am = a & mask;
        bv = b & mask;
        sa = (am >= half) ? am - (1 << w) : am;
        sb = (bv >= half) ? bv - (1 << w) : bv;
        c = m_c; dc = m_dc; ov = m_ov; r = 0;
        case (op)
            0, 1: begin
                cin = (op == 1) ? int'(m_c) : 0;
                s = am + bv + cin; r = s & mask; c = s > mask;
                dc = ((a & 15) + (b & 15) + cin) > 15;
                t = sa + sb + cin; ov = (t < -half) || (t > half - 1);
            end
            2, 3: begin
                bor = (op == 3) ? (m_c ? 0 : 1) : 0;
                s = am - bv - bor; r = s & mask; c = s >= 0;
                dc = ((a & 15) - (b & 15) - bor) >= 0;
                t = sa - sb - bor; ov = (t < -half) || (t > half - 1);
            end
            4: r = am & bv;
            5: r = am | bv;
            6: r = am ^ bv;
            7: begin r = (am << 1) & mask; c = ((am & half) != 0); end
            8: begin r = am >> 1; c = am & 1; end
            default: begin r = (am >> 1) | (am & half); c = am & 1; end
        endcase
        m_z = (op == 1 || op == 3) ? (m_z && r == 0) : (r == 0);
        m_n = (r & half) != 0;
        m_c = c; m_dc = dc; m_ov = ov;
        m_res = bm ? ((a & 'hFF00) | r) : r;
    endtask

    task automatic compare(input string tag);
        n_checks++;
        if (result !== m_res[15:0]) begin
            n_fail++;
            $display("FAIL %s result: actual %h expected %h", tag, result, m_res[15:0]);
        end
        n_checks++;
        if ({flag_c, flag_z, flag_n, flag_ov, flag_dc} !== {m_c, m_z, m_n, m_ov, m_dc}) begin
            n_fail++;
            $display("FAIL %s flags c,z,n,ov,dc: actual %b expected %b", tag,
                     {flag_c, flag_z, flag_n, flag_ov, flag_dc}, {m_c, m_z, m_n, m_ov, m_dc});
        end
    endtask

    task automatic step(input string tag, input int op, input int a, input int b,
                        input bit bm, input bit v);
        @(negedge clk);
        op_valid = v; op_code = op[3:0]; byte_mode = bm; opnd_a = a[15:0]; opnd_b = b[15:0];
        model(op, a, b, bm, v);
        @(posedge clk);
        #2;
        compare(tag);
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 compare("R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2 compare("R1 after release");
        step("R2 add", 0, 'h1234, 'h1111, 0, 1);
        step("R4 add overflow", 0, 'h7FFF, 'h0001, 0, 1);
        step("R2 R5 add carry to zero", 0, 'hFFFF, 'h0001, 0, 1);
        step("R6 addc keeps zero", 1, 'h0000, 'hFFFF, 0, 1);
        step("R2 addc uses carry", 1, 'h0001, 'h0000, 0, 1);
        step("R6 addc clears zero", 1, 'hFFFF, 'h0000, 0, 1);
        step("R6 addc zero stays clear", 1, 'h0001, 'hFFFF, 0, 1);
        step("R3 sub no borrow", 2, 'h0005, 'h0003, 0, 1);
        step("R3 sub borrow", 2, 'h0003, 'h0005, 0, 1);
        step("R3 subb with borrow in", 3, 'h0010, 'h0001, 0, 1);
        step("R4 sub overflow", 2, 'h8000, 'h0001, 0, 1);
        step("R5 nibble carry", 0, 'h000F, 'h0001, 0, 1);
        step("R9 byte add", 0, 'h1280, 'h0080, 1, 1);
        step("R9 byte sub", 2, 'hAB10, 'h7720, 1, 1);
        step("R7 and", 4, 'hF0F0, 'h0FF0, 0, 1);
        step("R7 or", 5, 'h0000, 'h0000, 0, 1);
        step("R7 xor", 6, 'hAAAA, 'h5555, 0, 1);
        step("R8 shl", 7, 'h8001, 0, 0, 1);
        step("R8 lsr", 8, 'h0003, 0, 0, 1);
        step("R8 asr", 9, 'h8002, 0, 0, 1);
        step("R8 R9 byte asr", 9, 'h3481, 0, 1, 1);
        step("R8 R9 byte shl", 7, 'h5680, 0, 1, 1);
        step("R10 idle", 0, 'hFFFF, 'hFFFF, 0, 0);
        step("R10 reserved", 12, 'h1234, 'h4321, 0, 1);
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 15));
            step("R2 R3 R7 R8 R9 R10 mixed", op, int'($urandom_range(0, 65535)),
                 int'($urandom_range(0, 65535)), bit'($urandom_range(0, 1)),
                 ($urandom_range(0, 7) != 0));
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule